// File: doc/BRIEF.md
# Paired write handler for the narrow analog-interface bus

This block takes one 32-bit configuration entry and issues its writes on a narrow bus that reaches the analog units. The entry names one of two units and selects half-size or full-size access. It also carries a first address and value and an optional second address and value. The block issues the first write, then the second if the entry holds one, and pulses a completion strobe after the last write.

The two writes happen one after the other. The second write starts only after the bus has acknowledged the first. The size flag and the unit select are latched once and apply to both writes. A second address of zero means the second slot is empty, so bus address 0 can be reached only through the first slot. In a full-size write the bus ignores the address LSB, and the block drives that bit as zero. In a half-size write the block sets the bus size bit and clears the upper half of the data.

A sequencer uses the block by holding an entry on `entryIn` and raising `startIn` for one cycle, then waiting for `doneOut`. The bus side is a valid/acknowledge pair. A write completes on a clock edge where both `busValid` and `busAck` are high.

Top module: `nbw_paired_write`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busValid` and `doneOut` are 0.
- R2: When `startIn` is high in the idle state and entry bits 1:0 equal the accepted type code (2'b10), the entry is latched. `busValid` rises in the next cycle for the first write. That write carries the unit from bit 2, the size flag from bit 3, the address from bits 9:4 and the value from bits 17:10.
- R3: When the size flag (bit 3) is 1, `busHalf` is 1 and the address is driven unchanged. `busData` carries the lower four bits of the value, and its upper four bits are 0.
- R4: When the size flag is 0, `busHalf` is 0 and `busAddr` bit 0 is driven as 0. `busData` carries the full eight-bit value.
- R5: When the second address (bits 23:18) is nonzero, a second write follows the first. It carries the second address and the second value (bits 31:24), with the same unit and size as the first. It is presented in the cycle after the first write is acknowledged.
- R6: When the second address is zero, exactly one write is issued, and the second value has no effect on the bus.
- R7: A presented write keeps `busValid` high and keeps its unit, size, address and data stable until the edge on which `busAck` is sampled high.
- R8: `doneOut` is high for exactly one cycle. That cycle is the one after the edge on which the last write was acknowledged.
- R9: `startIn` has no effect while a write or the completion cycle is in progress. It also has no effect when entry bits 1:0 differ from 2'b10: then no write and no `doneOut` follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | One-cycle request to execute `entryIn` |
| entryIn | input | 32 | Configuration entry (type, unit, size, two address/value slots) |
| busValid | output | 1 | A write is presented on the bus |
| busAck | input | 1 | Bus accepts the presented write at this edge |
| busUnit | output | 1 | Target analog unit |
| busHalf | output | 1 | Bus size bit: 1 for half-size write |
| busAddr | output | 6 | Bus register address |
| busData | output | 8 | Write data |
| doneOut | output | 1 | One-cycle pulse after the last write completes |

## Verification
The first write must be visible one cycle after the start edge. A second write must follow one cycle after the acknowledge of the first, and `doneOut` must rise one cycle after the acknowledge of the last write. It must then fall in the cycle after that. The bench drives inputs and samples outputs on the falling edge. This way every comparison falls a known number of rising edges after the stimulus: the start is checked at the first falling edge, and each acknowledge is followed by a check at the next one. In every cycle between start and completion, the bench requires either a presented write that matches the expected slot, or the completion strobe, so a missing or late cycle is reported. Acknowledge delays are random, which checks that a held write stays stable for any number of cycles.

// File: rtl/nbw_pkg.sv
package nbw_pkg;
  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic loadEntry;  // capture the entry fields
    logic selSecond;  // present the second slot on the bus
  } nbwStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_FIN    = 2'd3
  } nbwState_t;
endpackage

// File: rtl/nbw_datapath.sv
module nbw_datapath
  import nbw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int TYPE_W = 2,
  parameter logic [TYPE_W-1:0] TYPE_CODE = 2'b10,
  localparam int UNIT_POS = TYPE_W,
  localparam int HALF_POS = TYPE_W + 1,
  localparam int A1_LO = TYPE_W + 2,
  localparam int V1_LO = A1_LO + ADDR_W,
  localparam int A2_LO = V1_LO + DATA_W,
  localparam int V2_LO = A2_LO + ADDR_W,
  localparam int ENTRY_W = V2_LO + DATA_W,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ENTRY_W-1:0] entryIn,
  input  nbwStrobe_t         strobes,
  input  logic               busValid,
  input  logic               busAck,
  output logic               typeOk,
  output logic               secondPresent,
  output logic               busUnit,
  output logic               busHalf,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [DATA_W-1:0]  busData
);
  logic              unitQ, halfQ;
  logic [ADDR_W-1:0] addr1Q, addr2Q, addrSel;
  logic [DATA_W-1:0] val1Q, val2Q, valSel;

  assign typeOk = (entryIn[TYPE_W-1:0] == TYPE_CODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitQ  <= 1'b0;
      halfQ  <= 1'b0;
      addr1Q <= '0;
      addr2Q <= '0;
      val1Q  <= '0;
      val2Q  <= '0;
    end else if (strobes.loadEntry) begin
      unitQ  <= entryIn[UNIT_POS];
      halfQ  <= entryIn[HALF_POS];
      addr1Q <= entryIn[A1_LO +: ADDR_W];
      val1Q  <= entryIn[V1_LO +: DATA_W];
      addr2Q <= entryIn[A2_LO +: ADDR_W];
      val2Q  <= entryIn[V2_LO +: DATA_W];
    end
  end

  assign secondPresent = (addr2Q != '0);
  assign addrSel = strobes.selSecond ? addr2Q : addr1Q;
  assign valSel  = strobes.selSecond ? val2Q  : val1Q;

  assign busUnit = unitQ;
  assign busHalf = halfQ;
  // Full-size writes: the bus ignores the address LSB, so drive it low.
  assign busAddr = {addrSel[ADDR_W-1:1], addrSel[0] & halfQ};
  // Half-size writes: only the low half of the value is meaningful.
  assign busData = halfQ ? {{(DATA_W-HALF_W){1'b0}}, valSel[HALF_W-1:0]} : valSel;

  // R6: the second slot is presented only when its address is nonzero
  assert_second_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selSecond |-> (addr2Q != '0));

  // R7: a held write keeps its fields until accepted
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busAck) |=> ($stable(busAddr) && $stable(busData)
                               && $stable(busUnit) && $stable(busHalf)));

  // R3: half-size data never carries an upper half while presented
  assert_half_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busHalf) |-> (busData[DATA_W-1:HALF_W] == '0));
endmodule

// File: rtl/nbw_ctrl.sv
module nbw_ctrl
  import nbw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       typeOk,
  input  logic       secondPresent,
  input  logic       busAck,
  output nbwStrobe_t strobes,
  output logic       busValid,
  output logic       doneOut
);
  nbwState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (startIn && typeOk) stateD = ST_FIRST;
      ST_FIRST:  if (busAck) stateD = secondPresent ? ST_SECOND : ST_FIN;
      ST_SECOND: if (busAck) stateD = ST_FIN;
      ST_FIN:    stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign strobes.loadEntry = (stateQ == ST_IDLE) && startIn && typeOk;
  assign strobes.selSecond = (stateQ == ST_SECOND);
  assign busValid = (stateQ == ST_FIRST) || (stateQ == ST_SECOND);
  assign doneOut  = (stateQ == ST_FIN);

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R8: completion follows an accepted write
  assert_done_after_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> $past(busValid && busAck));

  // R7: a presented write is not withdrawn before acceptance
  assert_valid_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busAck) |=> busValid);

  // R9: a new entry is never captured while busy
  assert_no_load_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadEntry |-> (!busValid && !doneOut));
endmodule

// File: rtl/nbw_paired_write.sv
module nbw_paired_write
  import nbw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int TYPE_W = 2,
  parameter logic [TYPE_W-1:0] TYPE_CODE = 2'b10,
  localparam int ENTRY_W = TYPE_W + 2 + 2 * (ADDR_W + DATA_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  input  logic [ENTRY_W-1:0] entryIn,
  output logic               busValid,
  input  logic               busAck,
  output logic               busUnit,
  output logic               busHalf,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [DATA_W-1:0]  busData,
  output logic               doneOut
);
  nbwStrobe_t strobes;
  logic       typeOk;
  logic       secondPresent;

  nbw_ctrl ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .startIn       (startIn),
    .typeOk        (typeOk),
    .secondPresent (secondPresent),
    .busAck        (busAck),
    .strobes       (strobes),
    .busValid      (busValid),
    .doneOut       (doneOut)
  );

  nbw_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .TYPE_W    (TYPE_W),
    .TYPE_CODE (TYPE_CODE)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .entryIn       (entryIn),
    .strobes       (strobes),
    .busValid      (busValid),
    .busAck        (busAck),
    .typeOk        (typeOk),
    .secondPresent (secondPresent),
    .busUnit       (busUnit),
    .busHalf       (busHalf),
    .busAddr       (busAddr),
    .busData       (busData)
  );

  // R1: idle outputs right after reset release
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (!busValid && !doneOut));
endmodule

// File: tb/nbw_paired_write_tb_top.sv
`timescale 1ns/1ps
module nbw_paired_write_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [31:0] entryIn = '0;
  logic        busValid, busAck, busUnit, busHalf, doneOut;
  logic [5:0]  busAddr;
  logic [7:0]  busData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  nbw_paired_write dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .entryIn(entryIn),
    .busValid(busValid), .busAck(busAck), .busUnit(busUnit), .busHalf(busHalf),
    .busAddr(busAddr), .busData(busData), .doneOut(doneOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkEntry(input logic [7:0] v2, input logic [5:0] a2,
      input logic [7:0] v1, input logic [5:0] a1, input logic half, input logic unit,
      input logic [1:0] typ);
    return {v2, a2, v1, a1, half, unit, typ};
  endfunction

  function automatic int expCount(input logic [31:0] e);
    return (e[23:18] != 6'd0) ? 2 : 1;
  endfunction

  function automatic logic [5:0] expAddr(input logic [31:0] e, input int idx);
    logic [5:0] a;
    a = (idx == 0) ? e[9:4] : e[23:18];
    return e[3] ? a : {a[5:1], 1'b0};
  endfunction

  function automatic logic [7:0] expData(input logic [31:0] e, input int idx);
    logic [7:0] v;
    v = (idx == 0) ? e[17:10] : e[31:24];
    return e[3] ? {4'h0, v[3:0]} : v;
  endfunction

  // Runs one accepted entry; optionally pulses a second start while busy.
  task automatic runEntry(input logic [31:0] e, input bit inject, input logic [31:0] other);
    int idx = 0;
    bit justAcked = 1'b0;
    string szTag;
    szTag = e[3] ? "R3" : "R4";
    @(negedge clk);
    startIn = 1'b1; entryIn = e;
    @(negedge clk);
    startIn = 1'b0;
    check(busValid === 1'b1, "R2", "first write one cycle after start", busValid, 1);
    for (int cyc = 0; cyc < 100; cyc++) begin
      if (inject && cyc == 0) begin startIn = 1'b1; entryIn = other; end
      else if (inject && cyc == 1) begin startIn = 1'b0; entryIn = e; end
      if (doneOut === 1'b1) begin
        check(idx == expCount(e), (expCount(e) == 2) ? "R5" : "R6", "write count at done",
              idx, expCount(e));
        check(justAcked, "R8", "done one cycle after last ack", justAcked, 1);
        busAck = 1'b0;
        @(negedge clk);
        check(doneOut === 1'b0, "R8", "done is single cycle", doneOut, 0);
        check(busValid === 1'b0, "R9", "no write after done", busValid, 0);
        return;
      end
      if (busValid === 1'b1) begin
        check(idx < expCount(e), "R6", "extra write issued", idx, expCount(e));
        check(busUnit === e[2], (idx == 0) ? "R2" : "R5", "unit", busUnit, e[2]);
        check(busHalf === e[3], szTag, "size bit", busHalf, e[3]);
        check(busAddr === expAddr(e, idx), szTag, "address", busAddr, expAddr(e, idx));
        check(busData === expData(e, idx), szTag, "data", busData, expData(e, idx));
        busAck = (inject && cyc == 0) ? 1'b0 : (($urandom % 3) == 0);
        justAcked = busAck;
        if (busAck) idx++;
      end else begin
        check(1'b0, "R5", "idle gap before done", busValid, 1);
        busAck = 1'b0;
        justAcked = 1'b0;
      end
      @(negedge clk);
    end
    check(1'b0, "R8", "done never seen", 0, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    busAck = 1'b0;
    repeat (3) @(negedge clk);
    check(busValid === 1'b0 && doneOut === 1'b0, "R1", "outputs in reset",
          {busValid, doneOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busValid === 1'b0 && doneOut === 1'b0, "R1", "outputs after reset",
          {busValid, doneOut}, 0);

    // Directed: half-size, single write, odd address kept
    runEntry(mkEntry(8'hAB, 6'd0, 8'hF7, 6'd33, 1'b1, 1'b1, 2'b10), 1'b0, 0);
    // Directed: full-size, single write, odd address LSB cleared, value2 ignored (R6)
    runEntry(mkEntry(8'h5C, 6'd0, 8'h96, 6'd63, 1'b0, 1'b0, 2'b10), 1'b0, 0);
    // Directed: full-size pair (R5), both odd addresses
    runEntry(mkEntry(8'hC3, 6'd9, 8'h3C, 6'd1, 1'b0, 1'b1, 2'b10), 1'b0, 0);
    // Directed: half-size pair, first to address 0
    runEntry(mkEntry(8'hE5, 6'd1, 8'h1A, 6'd0, 1'b1, 1'b0, 2'b10), 1'b0, 0);
    // Directed: start during a write is ignored (R9)
    runEntry(mkEntry(8'h11, 6'd5, 8'h22, 6'd7, 1'b0, 1'b0, 2'b10), 1'b1,
             mkEntry(8'hFF, 6'd63, 8'hEE, 6'd62, 1'b1, 1'b1, 2'b10));
    // Directed: start during a single write/done is ignored (R9)
    runEntry(mkEntry(8'h00, 6'd0, 8'h44, 6'd12, 1'b1, 1'b1, 2'b10), 1'b1,
             mkEntry(8'h99, 6'd3, 8'h88, 6'd2, 1'b0, 1'b0, 2'b10));

    // R9: other type codes start nothing
    for (int t = 0; t < 4; t++) begin
      if (t == 2) continue;
      @(negedge clk);
      startIn = 1'b1;
      entryIn = mkEntry(8'h12, 6'd4, 8'h34, 6'd6, 1'b0, 1'b1, t[1:0]);
      @(negedge clk);
      startIn = 1'b0;
      for (int k = 0; k < 4; k++) begin
        check(busValid === 1'b0 && doneOut === 1'b0, "R9", "wrong type ignored",
              {busValid, doneOut}, 0);
        @(negedge clk);
      end
    end

    // Random entries
    for (int n = 0; n < 60; n++) begin
      logic [5:0] a2;
      a2 = (($urandom % 4) == 0) ? 6'd0 : 6'($urandom);
      runEntry(mkEntry(8'($urandom), a2, 8'($urandom), 6'($urandom),
                       1'($urandom), 1'($urandom), 2'b10), 1'b0, 0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule